// File: doc/BRIEF.md
# NAND Page Access Command Sequencer

This block turns one page request into the bus cycles a raw NAND device expects. A request names the operation (read or program), a page number and a spare-only flag. It also carries the device geometry: small or large page class, the configured address-cycle count and an 8- or 16-bit bus. The block then emits the opening command, the column and row address bytes and, for large-page reads, the read-start command. It moves the data and spare transfers, and for programs it closes the operation by confirming the program and polling the device status.

Every device-side cycle goes out on one valid/ready port that carries a kind code and a data word. Write data enters on a valid/ready stream and passes through to write cycles without buffering. Read data leaves on a valid/ready stream that is fed straight from the read cycles. When the operation ends, a one-cycle `done` pulse appears together with the pass/fail and timeout flags. The flags stay valid until the next request.

Top module: `nand_page_seq`

## Requirements
- R1: The first cycle of an operation is a command cycle (kind 0). Its code is 0x80 for a program. For a read it is 0x50 when the device is small-page and spare-only is set, and 0x00 in every other read case.
- R2: On a small-page device the command is followed by address cycles (kind 1) in this order: one column byte 0x00, then page bits [7:0] and page bits [15:8]. Page bits [23:16] follow when the configured cycle count is 4 or more, and page bits [31:24] (zero beyond the page width) follow when it is 5 or more.
- R3: On a large-page device the command is followed by two column bytes. These are 0x00 then 0x00 when data is accessed, or 0x00 then 0x08 when spare-only is set. Then come page bits [7:0] and [15:8], plus page bits [23:16] when the cycle count is 5 or more.
- R4: A large-page read issues command 0x30 right after its last address cycle. A small-page read does not.
- R5: A read issues no data read cycle (kind 3) until `dev_rdy` has been sampled high after the final command or address cycle.
- R6: The transfer phase holds the data transfers followed by the spare transfers. A spare-only access skips the data transfers. Each part takes `len` transfers on an 8-bit bus and `ceil(len/2)` transfers on a 16-bit bus. `out_last` is high on the final read transfer only.
- R7: A program sends one write cycle (kind 2) per transfer, carrying `in_data` in stream order. It then sends command 0x10 and then status command 0x70.
- R8: After 0x70 the block issues status read cycles until a returned word has bit 6 set. At that point `res_fail` equals bit 0 of that word.
- R9: If POLL_MAX status reads all return bit 6 clear, the block ends with `res_timeout` high and `res_fail` low and issues no further status read.
- R10: A `start` pulse while `busy` is high is ignored. The running operation's cycles are unchanged.
- R11: A command or address cycle holds `cyc_valid`, `cyc_kind` and `cyc_data` until `cyc_ready`. A write transfer is accepted only when both `in_valid` and `cyc_ready` are high. A read transfer moves only when `out_ready` and `cyc_ready` are both high.
- R12: After reset `busy`, `done`, `cyc_valid` and `out_valid` are low. `done` pulses for one cycle, the cycle after the final accepted cycle, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled in idle only) |
| op_prog | input | 1 | 1 = program, 0 = read |
| oob_only | input | 1 | Access the spare area only |
| large_page | input | 1 | 1 = large-page device |
| bus16 | input | 1 | 1 = 16-bit device bus |
| addr_cycles | input | 3 | Configured address-cycle count |
| page | input | PAGE_W | Page number |
| data_len | input | LEN_W | Data bytes to move |
| oob_len | input | LEN_W | Spare bytes to move |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| res_fail | output | 1 | Program reported failure |
| res_timeout | output | 1 | Status never showed ready |
| cyc_valid | output | 1 | Bus cycle offered |
| cyc_ready | input | 1 | Bus cycle accepted |
| cyc_kind | output | 2 | 0 command, 1 address, 2 write, 3 read |
| cyc_data | output | 16 | Command, address or write word |
| cyc_rdata | input | 16 | Word returned by a read cycle |
| dev_rdy | input | 1 | Device ready (high) / busy (low) |
| in_valid | input | 1 | Write stream valid |
| in_ready | output | 1 | Write stream ready |
| in_data | input | 16 | Write stream word |
| out_valid | output | 1 | Read stream valid |
| out_ready | input | 1 | Read stream ready |
| out_data | output | 16 | Read stream word |
| out_last | output | 1 | Final read transfer |

## Verification
The first command cycle is offered in the cycle after `start` is sampled. Each later cycle is offered in the cycle after the previous one is accepted, and `done` rises one cycle after the final acceptance. The bench drives `cyc_ready`, the stream handshakes and `dev_rdy` at the falling edge. It then waits a short settle and records every accepted cycle before the next rising edge, so each check looks at exactly the cycle that the rising edge will consume. The recorded cycles are compared in order against a list that the bench builds from the request. The read stream, the last flag and the result flags seen at the `done` pulse are checked in the same way.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {
    CYC_CMD  = 2'd0,
    CYC_ADDR = 2'd1,
    CYC_WR   = 2'd2,
    CYC_RD   = 2'd3
  } cyc_kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_RSTART, S_WAIT, S_DATA, S_CONF, S_STCMD, S_STRD
  } seq_state_t;

  localparam logic [7:0] OPC_READ       = 8'h00;
  localparam logic [7:0] OPC_READ_SPARE = 8'h50;
  localparam logic [7:0] OPC_READ_GO    = 8'h30;
  localparam logic [7:0] OPC_LOAD       = 8'h80;
  localparam logic [7:0] OPC_COMMIT     = 8'h10;
  localparam logic [7:0] OPC_STATUS     = 8'h70;
  localparam int         STAT_RDY_BIT   = 6;
  localparam int         STAT_ERR_BIT   = 0;
endpackage

// File: rtl/nand_addr_gen.sv
module nand_addr_gen #(
  parameter int PAGE_W = 24
) (
  input  logic [PAGE_W-1:0] page,
  input  logic              large_page,
  input  logic              oob_only,
  input  logic [2:0]        addr_cycles,
  input  logic [2:0]        idx,
  output logic [2:0]        naddr,
  output logic [7:0]        abyte
);
  localparam int EXT_W = PAGE_W + 32;

  logic [EXT_W-1:0] pg_ext;
  logic [2:0]       row_k;
  logic             more4;
  logic             more5;

  assign pg_ext = {32'd0, page};
  assign more4  = (addr_cycles >= 3'd4);
  assign more5  = (addr_cycles >= 3'd5);

  always_comb begin
    if (large_page) naddr = 3'd4 + {2'b00, more5};
    else            naddr = 3'd3 + {2'b00, more4} + {2'b00, more5};
  end

  always_comb begin
    row_k = large_page ? (idx - 3'd2) : (idx - 3'd1);
    if (idx == 3'd0)
      abyte = 8'h00;
    else if (large_page && idx == 3'd1)
      abyte = oob_only ? 8'h08 : 8'h00;
    else
      abyte = pg_ext[{row_k, 3'b000} +: 8];
  end
endmodule

// File: rtl/nand_xfer_ctr.sv
module nand_xfer_ctr #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         one
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - W'(1);
  end

  assign one = (cnt == W'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> (cnt != '0)); // R6
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_W   = 24,
  parameter int LEN_W    = 13,
  parameter int POLL_MAX = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_prog,
  input  logic              oob_only,
  input  logic              large_page,
  input  logic              bus16,
  input  logic [2:0]        addr_cycles,
  input  logic [PAGE_W-1:0] page,
  input  logic [LEN_W-1:0]  data_len,
  input  logic [LEN_W-1:0]  oob_len,
  output logic              busy,
  output logic              done,
  output logic              res_fail,
  output logic              res_timeout,
  output logic              cyc_valid,
  input  logic              cyc_ready,
  output logic [1:0]        cyc_kind,
  output logic [15:0]       cyc_data,
  input  logic [15:0]       cyc_rdata,
  input  logic              dev_rdy,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [15:0]       out_data,
  output logic              out_last
);
  localparam int POLL_W = $clog2(POLL_MAX + 1);

  function automatic logic [LEN_W-1:0] xfers(input logic [LEN_W-1:0] len,
                                             input logic wide);
    return wide ? ((len >> 1) + {{(LEN_W-1){1'b0}}, len[0]}) : len;
  endfunction

  seq_state_t         st;
  logic               q_prog, q_oob, q_large;
  logic [2:0]         q_ac;
  logic [PAGE_W-1:0]  q_page;
  logic [LEN_W-1:0]   q_dx, q_ox;
  logic [2:0]         aidx;
  logic               phase_oob;

  logic [2:0]         naddr;
  logic [7:0]         abyte;
  logic               accept;
  logic               addr_last;
  logic               enter_data;
  logic               stat_ok;

  logic               d_load, d_dec, d_one;
  logic [LEN_W-1:0]   d_val, d_cnt;
  logic               p_load, p_dec, p_one;
  logic [POLL_W-1:0]  p_cnt;

  nand_addr_gen #(.PAGE_W(PAGE_W)) u_addr (
    .page(q_page), .large_page(q_large), .oob_only(q_oob),
    .addr_cycles(q_ac), .idx(aidx), .naddr(naddr), .abyte(abyte)
  );

  nand_xfer_ctr #(.W(LEN_W)) u_dctr (
    .clk(clk), .rst_n(rst_n), .load(d_load), .load_val(d_val),
    .dec(d_dec), .cnt(d_cnt), .one(d_one)
  );

  nand_xfer_ctr #(.W(POLL_W)) u_pctr (
    .clk(clk), .rst_n(rst_n), .load(p_load), .load_val(POLL_W'(POLL_MAX)),
    .dec(p_dec), .cnt(p_cnt), .one(p_one)
  );

  // Bus cycle offered in each state.
  always_comb begin
    cyc_valid = 1'b0;
    cyc_kind  = CYC_CMD;
    cyc_data  = 16'h0000;
    unique case (st)
      S_CMD: begin
        cyc_valid = 1'b1;
        if (q_prog)                cyc_data = {8'h00, OPC_LOAD};
        else if (!q_large && q_oob) cyc_data = {8'h00, OPC_READ_SPARE};
        else                       cyc_data = {8'h00, OPC_READ};
      end
      S_ADDR: begin
        cyc_valid = 1'b1;
        cyc_kind  = CYC_ADDR;
        cyc_data  = {8'h00, abyte};
      end
      S_RSTART: begin
        cyc_valid = 1'b1;
        cyc_data  = {8'h00, OPC_READ_GO};
      end
      S_DATA: begin
        if (q_prog) begin
          cyc_valid = in_valid;
          cyc_kind  = CYC_WR;
          cyc_data  = in_data;
        end else begin
          cyc_valid = out_ready;
          cyc_kind  = CYC_RD;
        end
      end
      S_CONF: begin
        cyc_valid = 1'b1;
        cyc_data  = {8'h00, OPC_COMMIT};
      end
      S_STCMD: begin
        cyc_valid = 1'b1;
        cyc_data  = {8'h00, OPC_STATUS};
      end
      S_STRD: begin
        cyc_valid = 1'b1;
        cyc_kind  = CYC_RD;
      end
      default: ;
    endcase
  end

  assign accept    = cyc_valid && cyc_ready;
  assign addr_last = (aidx == naddr - 3'd1);
  assign stat_ok   = cyc_rdata[STAT_RDY_BIT];
  assign busy      = (st != S_IDLE);

  assign in_ready  = (st == S_DATA) && q_prog && cyc_ready;
  assign out_valid = (st == S_DATA) && !q_prog && accept;
  assign out_data  = cyc_rdata;
  assign out_last  = out_valid && d_one && (phase_oob || q_ox == '0);

  assign enter_data = ((st == S_WAIT) && dev_rdy) ||
                      ((st == S_ADDR) && accept && addr_last && q_prog);

  // Transfer and poll counter control.
  always_comb begin
    d_load = 1'b0;
    d_val  = '0;
    d_dec  = 1'b0;
    if (enter_data) begin
      if (q_dx != '0)      begin d_load = 1'b1; d_val = q_dx; end
      else if (q_ox != '0) begin d_load = 1'b1; d_val = q_ox; end
    end else if ((st == S_DATA) && accept) begin
      if (d_one && !phase_oob && q_ox != '0) begin
        d_load = 1'b1;
        d_val  = q_ox;
      end else begin
        d_dec = 1'b1;
      end
    end
  end

  assign p_load = (st == S_STCMD) && accept;
  assign p_dec  = (st == S_STRD) && accept && !stat_ok && !p_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      done        <= 1'b0;
      res_fail    <= 1'b0;
      res_timeout <= 1'b0;
      q_prog      <= 1'b0;
      q_oob       <= 1'b0;
      q_large     <= 1'b0;
      q_ac        <= 3'd0;
      q_page      <= '0;
      q_dx        <= '0;
      q_ox        <= '0;
      aidx        <= 3'd0;
      phase_oob   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          q_prog      <= op_prog;
          q_oob       <= oob_only;
          q_large     <= large_page;
          q_ac        <= addr_cycles;
          q_page      <= page;
          q_dx        <= oob_only ? '0 : xfers(data_len, bus16);
          q_ox        <= xfers(oob_len, bus16);
          res_fail    <= 1'b0;
          res_timeout <= 1'b0;
          aidx        <= 3'd0;
          st          <= S_CMD;
        end
        S_CMD: if (accept) st <= S_ADDR;
        S_ADDR: if (accept) begin
          if (!addr_last)   aidx <= aidx + 3'd1;
          else if (!q_prog) st <= q_large ? S_RSTART : S_WAIT;
        end
        S_RSTART: if (accept) st <= S_WAIT;
        S_DATA: if (accept && d_one) begin
          if (!phase_oob && q_ox != '0) phase_oob <= 1'b1;
          else if (q_prog)              st <= S_CONF;
          else begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_CONF:  if (accept) st <= S_STCMD;
        S_STCMD: if (accept) st <= S_STRD;
        S_STRD: if (accept) begin
          if (stat_ok) begin
            res_fail <= cyc_rdata[STAT_ERR_BIT];
            st       <= S_IDLE;
            done     <= 1'b1;
          end else if (p_one) begin
            res_timeout <= 1'b1;
            st          <= S_IDLE;
            done        <= 1'b1;
          end
        end
        default: ;
      endcase
      // Shared entry into the transfer phase (read after ready, program after address).
      if (enter_data) begin
        if (q_dx != '0) begin
          phase_oob <= 1'b0;
          st        <= S_DATA;
        end else if (q_ox != '0) begin
          phase_oob <= 1'b1;
          st        <= S_DATA;
        end else if (q_prog) begin
          st <= S_CONF;
        end else begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
      end
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ready && (cyc_kind == CYC_CMD || cyc_kind == CYC_ADDR))
      |=> (cyc_valid && $stable(cyc_kind) && $stable(cyc_data))); // R11
  AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(q_page) && $stable(q_prog) && $stable(q_oob))); // R10
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(res_fail && res_timeout)); // R8
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR) |-> (aidx < naddr)); // R2
  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, in_valid && in_ready})); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cyc_valid); // R12
endmodule

// File: tb/sim_nand_page_seq.sv
`timescale 1ns/1ps
module sim_nand_page_seq;
  localparam int PAGE_W = 24, LEN_W = 13, POLL_MAX = 100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, op_prog, oob_only, large_page, bus16;
  logic [2:0] addr_cycles;
  logic [PAGE_W-1:0] page;
  logic [LEN_W-1:0] data_len, oob_len;
  logic busy, done, res_fail, res_timeout;
  logic cyc_valid, cyc_ready;
  logic [1:0] cyc_kind;
  logic [15:0] cyc_data, cyc_rdata;
  logic dev_rdy, in_valid, in_ready, out_valid, out_ready, out_last;
  logic [15:0] in_data, out_data;

  nand_page_seq #(.PAGE_W(PAGE_W), .LEN_W(LEN_W), .POLL_MAX(POLL_MAX)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .oob_only(oob_only),
    .large_page(large_page), .bus16(bus16), .addr_cycles(addr_cycles), .page(page),
    .data_len(data_len), .oob_len(oob_len), .busy(busy), .done(done),
    .res_fail(res_fail), .res_timeout(res_timeout), .cyc_valid(cyc_valid),
    .cyc_ready(cyc_ready), .cyc_kind(cyc_kind), .cyc_data(cyc_data),
    .cyc_rdata(cyc_rdata), .dev_rdy(dev_rdy), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  int checks = 0, failures = 0;
  logic [1:0]  ek [0:255];
  logic [15:0] ed [0:255];
  int en, pre_n, exp_out_n, wr_total;
  bit exp_fail, exp_to;
  logic [1:0]  lk [0:255];
  logic [15:0] ld [0:255];
  int ln;
  logic [15:0] orx [0:63];
  bit olast [0:63];
  int on;
  int rd_idx, wr_idx, st_reads, busy_polls, rdy_delay, busy_cnt;
  bit st_phase, failbit, bp, is_read, done_seen, got_fail, got_to, rd_early, active;

  function automatic logic [15:0] pat(input int i);
    return 16'hA55A ^ 16'(i * 259);
  endfunction

  function automatic int xf(input int len, input bit b16);
    return b16 ? (len + 1) / 2 : len;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [15:0] d);
    ek[en] = k; ed[en] = d; en++;
  endtask

  // Expected cycle list from the requirements.
  task automatic build_exp();
    int n, polls;
    en = 0;
    push(2'd0, op_prog ? 16'h80 : ((!large_page && oob_only) ? 16'h50 : 16'h00));
    push(2'd1, 16'h00);
    if (large_page) push(2'd1, oob_only ? 16'h08 : 16'h00);
    push(2'd1, {8'h00, page[7:0]});
    push(2'd1, {8'h00, page[15:8]});
    if (!large_page) begin
      if (addr_cycles >= 4) push(2'd1, {8'h00, page[23:16]});
      if (addr_cycles >= 5) push(2'd1, 16'h00);
    end else if (addr_cycles >= 5) push(2'd1, {8'h00, page[23:16]});
    if (!op_prog && large_page) push(2'd0, 16'h30);
    pre_n = en;
    n = (oob_only ? 0 : xf(int'(data_len), bus16)) + xf(int'(oob_len), bus16);
    for (int i = 0; i < n; i++) push(op_prog ? 2'd2 : 2'd3, op_prog ? pat(i) : 16'h0);
    wr_total = op_prog ? n : 0;
    exp_out_n = op_prog ? 0 : n;
    exp_fail = 0; exp_to = 0;
    if (op_prog) begin
      push(2'd0, 16'h10);
      push(2'd0, 16'h70);
      polls = (busy_polls >= POLL_MAX) ? POLL_MAX : busy_polls + 1;
      for (int i = 0; i < polls; i++) push(2'd3, 16'h0);
      exp_to = (busy_polls >= POLL_MAX);
      exp_fail = !exp_to && failbit;
    end
  endtask

  // Device and stream model: drive at the falling edge, record after settling.
  always @(negedge clk) begin
    if (rst_n && active) begin
      cyc_ready = bp ? (($urandom % 4) != 0) : 1'b1;
      out_ready = bp ? (($urandom % 3) != 0) : 1'b1;
      in_valid  = (wr_idx < wr_total) && (bp ? (($urandom % 3) != 0) : 1'b1);
      in_data   = pat(wr_idx);
      dev_rdy   = (busy_cnt == 0);
      if (busy_cnt > 0) busy_cnt--;
      cyc_rdata = st_phase ? ((st_reads >= busy_polls) ? (16'h0040 | 16'(failbit)) : 16'h0000)
                           : pat(rd_idx);
      #1;
      if (cyc_valid && cyc_ready) begin
        if (ln < 256) begin lk[ln] = cyc_kind; ld[ln] = cyc_data; end
        ln++;
        if (cyc_kind == 2'd0 && cyc_data == 16'h70) st_phase = 1;
        if (cyc_kind == 2'd3) begin
          if (st_phase) st_reads++;
          else begin
            if (!dev_rdy) rd_early = 1;
            rd_idx++;
          end
        end
        if (cyc_kind == 2'd2) wr_idx++;
        if (is_read && ln == pre_n && rdy_delay > 0) begin
          dev_rdy = 1'b0;
          busy_cnt = rdy_delay;
        end
      end
      if (out_valid && out_ready) begin
        if (on < 64) begin orx[on] = out_data; olast[on] = out_last; end
        on++;
      end
      if (done) begin
        done_seen = 1; got_fail = res_fail; got_to = res_timeout;
        chk(!busy, "R12", "busy during done", busy, 0);
      end
    end
  end

  task automatic run_op(input bit prg, input bit oob, input bit lg, input bit b16,
                        input int ac, input int pg, input int dl, input int ol,
                        input int bpolls, input bit fb, input int rdel, input bit bpm,
                        input bit mid, input string tag);
    int guard;
    bit seq_ok;
    @(negedge clk);
    op_prog = prg; oob_only = oob; large_page = lg; bus16 = b16;
    addr_cycles = 3'(ac); page = PAGE_W'(pg); data_len = LEN_W'(dl); oob_len = LEN_W'(ol);
    busy_polls = bpolls; failbit = fb; rdy_delay = rdel; bp = bpm; is_read = !prg;
    build_exp();
    ln = 0; on = 0; rd_idx = 0; wr_idx = 0; st_reads = 0; busy_cnt = 0;
    st_phase = 0; done_seen = 0; rd_early = 0; active = 1;
    start = 1'b1;
    @(negedge clk);
    #2 start = 1'b0;
    if (mid) begin
      repeat (2) @(negedge clk);
      #2;
      page = ~page; op_prog = ~op_prog; oob_only = ~oob_only; start = 1'b1;
      @(negedge clk);
      #2 start = 1'b0;
    end
    guard = 0;
    while (!done_seen && guard < 3000) begin @(negedge clk); guard++; end
    #2;
    active = 0;
    if (!done_seen) chk(0, tag, "operation never finished", 0, 1);
    chk(ln == en, tag, "cycle count", ln, en);
    seq_ok = (ln == en);
    for (int i = 0; i < en && i < ln; i++) begin
      if (lk[i] != ek[i] || (ek[i] != 2'd3 && ld[i] != ed[i])) begin
        if (seq_ok) chk(0, tag, $sformatf("cycle %0d kind/data", i),
                        {lk[i], ld[i]}, {ek[i], ed[i]});
        seq_ok = 0;
      end
    end
    if (seq_ok) chk(1, tag, "cycles", 0, 0);
    chk(!rd_early, "R5", "read cycle while device busy", rd_early, 0);
    chk(on == exp_out_n, "R6", "read transfers", on, exp_out_n);
    for (int i = 0; i < on && i < exp_out_n; i++) begin
      if (orx[i] != pat(i) || olast[i] != (i == exp_out_n - 1))
        chk(0, "R6", $sformatf("read word %0d data/last", i),
            {olast[i], orx[i]}, {(i == exp_out_n - 1), pat(i)});
    end
    chk(got_fail == exp_fail, "R8", "res_fail", got_fail, exp_fail);
    chk(got_to == exp_to, "R9", "res_timeout", got_to, exp_to);
  endtask

  initial begin
    #(5.0 * 190000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    active = 0; rst_n = 1'b0; start = 1'b0; op_prog = 0; oob_only = 0; large_page = 0;
    bus16 = 0; addr_cycles = 3'd3; page = '0; data_len = '0; oob_len = '0;
    cyc_ready = 1'b0; cyc_rdata = '0; dev_rdy = 1'b1; in_valid = 1'b0; in_data = '0;
    out_ready = 1'b0; busy_cnt = 0; bp = 0;
    repeat (4) @(posedge clk);
    #1;
    chk(!busy && !done && !cyc_valid && !out_valid, "R12", "reset outputs",
        {busy, done, cyc_valid, out_valid}, 0);
    @(negedge clk) rst_n = 1'b1;

    run_op(0, 0, 0, 0, 3, 24'h12AB34, 6, 2, 0, 0, 3, 0, 0, "R1/R2");
    run_op(0, 1, 0, 0, 4, 24'h5A0C77, 9, 4, 0, 0, 2, 0, 0, "R1/R2");
    run_op(1, 0, 0, 0, 5, 24'hC3D2E1, 5, 3, 3, 0, 0, 0, 0, "R2/R7");
    run_op(0, 0, 1, 1, 4, 24'h0F1E2D, 7, 3, 0, 0, 4, 0, 0, "R3/R4");
    run_op(0, 1, 1, 0, 5, 24'hABCDEF, 8, 5, 0, 0, 1, 0, 0, "R3/R4");
    run_op(1, 1, 1, 1, 5, 24'h13579B, 6, 6, 0, 1, 0, 0, 0, "R3/R8");
    run_op(1, 0, 0, 1, 3, 24'h000102, 3, 1, 200, 0, 0, 0, 0, "R7/R9");
    run_op(0, 0, 1, 0, 4, 24'h4455AA, 4, 2, 0, 0, 2, 0, 1, "R10");
    run_op(1, 0, 1, 0, 4, 24'h2468AC, 4, 2, 1, 0, 0, 0, 1, "R10");
    run_op(0, 0, 0, 0, 3, 24'h000009, 0, 0, 0, 0, 2, 0, 0, "R6");
    run_op(1, 0, 1, 0, 5, 24'h7F00FF, 6, 4, 2, 1, 0, 1, 0, "R11");
    run_op(0, 0, 1, 1, 5, 24'h123456, 9, 5, 0, 0, 3, 1, 0, "R11");

    for (int t = 0; t < 30; t++) begin
      run_op(bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2),
             3 + int'($urandom % 3), int'($urandom), int'($urandom % 25), int'($urandom % 9),
             int'($urandom % 6), bit'($urandom % 2), int'($urandom % 5), bit'($urandom % 2),
             0, "R1/R7/R11");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule